// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block is a bus master that works through a ring of transmit descriptors held in system memory and turns every frame the host has handed over into a byte stream. Software places an initialisation area in memory. The engine finds it by adding a DMA offset to the init pointer. A fixed number of bytes into that area sits a table of 8-byte descriptors, one for each ring slot. A second fixed region holds one packet buffer for each slot, each buffer a fixed size.

A scan starts when a trigger pulse arrives. The host pulses the trigger after every write to its register port, or as an explicit poll. A scan is refused while the run state reports stopped. A scan starts at the current ring index and looks at every slot except the one just before that index. Each slot is checked as follows:

- The engine reads the slot's flag byte.
- If the slot is ready, the engine reads the negated length.
- It then streams the buffer bytes out.
- It marks the slot complete in memory.
- It raises a one-cycle done pulse.

Top module: `txr_ring_engine`

## Requirements
- R1: After reset the engine is idle. `mem_req`, `tx_valid` and `tx_done` are low, and the ring index is 0, so the first scan starts at slot 0.
- R2: While `stop_i` is high, no scan starts and no memory request is issued. A trigger that arrives while stopped is discarded and does not run after `stop_i` falls.
- R3: A slot is ready only when its flag byte equals exactly 0x83. The flag byte is at byte offset 2 of the descriptor, which is bits [15:8] of the big-endian word at descriptor offset 0. A slot with any other flag value is neither sent nor written.
- R4: The length is the halfword at descriptor offset 4, stored big-endian, so it is bits [31:16] of the word at offset 4. The frame byte count is the two's-complement negation of this value, limited to `BUF_BYTES`. A count of zero streams no bytes but still completes the slot.
- R5: Frame bytes are read in ascending address order, starting at base + `BUF_OFS` + slot × `BUF_BYTES`. The base is `init_ptr` + `dma_off`. Within a 32-bit word the lowest address is in bits [31:24]. `tx_last` is high only on the final byte of each frame.
- R6: On completion the engine writes 0x03 to the flag byte using `mem_be` = 4'b0010, at word address base + `RING_OFS` + 8 × slot. `tx_done` pulses for one cycle right after the acknowledge of that write, once per frame.
- R7: A scan visits the slots in ring order from the index held at scan start, for N−1 slots. The slot just before the start index is not visited in that pass.
- R8: The ring index advances by exactly one, modulo N, for each frame sent. It does not move to the position after the slot that was sent.
- R9: A trigger that arrives while a scan is in progress is remembered, and causes exactly one further scan once the current scan ends.
- R10: A memory request holds its address and direction until `mem_ack`. A stream byte holds its value and `tx_last` until `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_trig | input | 1 | Scan request pulse (register write or poll) |
| stop_i | input | 1 | Run state: high means stopped |
| init_ptr | input | ADDR_W | Init area pointer |
| dma_off | input | ADDR_W | DMA offset added to the init pointer |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the accessed word (word aligned) |
| mem_be | output | 4 | Byte-lane enables for writes, bit 3 = lowest address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data, big-endian byte lanes |
| tx_valid | output | 1 | Frame byte valid |
| tx_data | output | 8 | Frame byte |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| tx_done | output | 1 | One-cycle pulse per completed frame |

## Verification
The hardest situation to reach from the ports is a trigger that lands in the middle of a scan and has to be queued. A second, related case is telling the index advance from the position of the sent slot. The bench reaches the first case by arming a 60-byte frame alone and waiting for its first streamed byte. It then arms the slot just behind the start index, which the running pass never visits, and pulses the trigger. Only a queued second scan can send that slot. For the index rule, the bench re-arms both the slot before the correct next index and the slot before the index a position-based advance would give. Each of these two outcomes then produces a different set of frames.

// File: rtl/txr_pkg.sv
package txr_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RD_FLAG,
      S_RD_LEN,
      S_RD_BUF,
      S_SEND,
      S_WR_BACK,
      S_NEXT
   } txr_state_e;

   localparam logic [7:0] TXR_FLAG_READY = 8'h83;
   localparam logic [7:0] TXR_FLAG_DONE  = 8'h03;
   localparam int         TXR_DESC_BYTES = 8;

endpackage

// File: rtl/txr_byte_lane.sv
module txr_byte_lane #(
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [31:0] word_i,
   input  logic [1:0]  sel_i,
   output logic [7:0]  byte_o
);
   generate
      if (BIG_ENDIAN) begin : g_big
         always_comb begin
            case (sel_i)
               2'd0:    byte_o = word_i[31:24];
               2'd1:    byte_o = word_i[23:16];
               2'd2:    byte_o = word_i[15:8];
               default: byte_o = word_i[7:0];
            endcase
         end
      end else begin : g_little
         always_comb begin
            case (sel_i)
               2'd0:    byte_o = word_i[7:0];
               2'd1:    byte_o = word_i[15:8];
               2'd2:    byte_o = word_i[23:16];
               default: byte_o = word_i[31:24];
            endcase
         end
      end
   endgenerate
endmodule

// File: rtl/txr_trig_queue.sv
module txr_trig_queue (
   input  logic clk,
   input  logic rst_n,
   input  logic trig_i,
   input  logic take_i,
   input  logic drop_i,
   output logic pend_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)                pend_o <= 1'b0;
      else if (take_i || drop_i) pend_o <= 1'b0;
      else if (trig_i)           pend_o <= 1'b1;
   end

   // R9: a trigger that is not consumed at once is remembered
   assert_trig_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && !take_i && !drop_i) |=> pend_o);

   // R2: a stopped idle engine forgets any trigger
   assert_trig_dropped_R2: assert property (@(posedge clk) disable iff (!rst_n)
      drop_i |=> !pend_o);
endmodule

// File: rtl/txr_ring_idx.sv
module txr_ring_idx #(
   parameter int RING_LOG2 = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_i,
   input  logic                 step_i,
   input  logic                 sent_i,
   output logic [RING_LOG2-1:0] entry_o,
   output logic                 last_o
);
   localparam int RING_N = 1 << RING_LOG2;
   localparam logic [RING_LOG2-1:0] LAST_K = RING_LOG2'(RING_N - 2);

   logic [RING_LOG2-1:0] ptr_q;
   logic [RING_LOG2-1:0] origin_q;
   logic [RING_LOG2-1:0] k_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q    <= '0;
         origin_q <= '0;
         k_q      <= '0;
      end else begin
         if (start_i) begin
            origin_q <= ptr_q;
            k_q      <= '0;
         end else if (step_i) begin
            k_q <= k_q + 1'b1;
         end
         if (sent_i) ptr_q <= ptr_q + 1'b1;
      end
   end

   assign entry_o = origin_q + k_q;
   assign last_o  = (k_q == LAST_K);

   // R7: the controller never steps past the final slot of a pass
   assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step_i |-> !last_o);

   // R7: the visited slot only moves on a step or a new scan
   assert_entry_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!start_i && !step_i) |=> $stable(entry_o));
endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine #(
   parameter int ADDR_W     = 32,
   parameter int RING_LOG2  = 4,
   parameter int RING_OFS   = 152,
   parameter int BUF_OFS    = 280,
   parameter int BUF_BYTES  = 1544,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scan_trig,
   input  logic              stop_i,
   input  logic [ADDR_W-1:0] init_ptr,
   input  logic [ADDR_W-1:0] dma_off,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [3:0]        mem_be,
   output logic [31:0]       mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   output logic              tx_valid,
   output logic [7:0]        tx_data,
   output logic              tx_last,
   input  logic              tx_ready,
   output logic              tx_done
);
   import txr_pkg::*;

   localparam int LEN_W = 16;
   localparam int CNT_W = $clog2(BUF_BYTES + 1);
   localparam logic [3:0] FLAG_BE = BIG_ENDIAN ? 4'b0010 : 4'b0100;
   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(BUF_BYTES);

   generate
      if (BUF_BYTES < 1 || BUF_BYTES >= (1 << LEN_W)) begin : g_bad_buf
         $error("BUF_BYTES must fit the 16-bit length field");
      end
      if (RING_LOG2 < 1 || RING_LOG2 > 8) begin : g_bad_ring
         $error("RING_LOG2 out of range");
      end
      if ((RING_OFS % 4) != 0 || (BUF_OFS % 4) != 0) begin : g_bad_ofs
         $error("region offsets must be word aligned");
      end
      if (ADDR_W < 16) begin : g_bad_addr
         $error("ADDR_W too small");
      end
   endgenerate

   txr_state_e state_q;
   logic [CNT_W-1:0]     cnt_q;
   logic [ADDR_W-1:0]    baddr_q;
   logic [31:0]          word_q;
   logic                 done_q;

   logic                 pend;
   logic                 take;
   logic                 drop;
   logic                 step;
   logic                 sent;
   logic [RING_LOG2-1:0] entry;
   logic                 last_entry;

   logic [ADDR_W-1:0]    base;
   logic [ADDR_W-1:0]    desc_addr;
   logic [ADDR_W-1:0]    buf_start;
   logic [7:0]           flag_byte;
   logic [7:0]           len_hi;
   logic [7:0]           len_lo;
   logic [LEN_W-1:0]     neg_len;
   logic [CNT_W-1:0]     cnt_load;

   assign take = (state_q == S_IDLE) && !stop_i && (scan_trig || pend);
   assign drop = (state_q == S_IDLE) && stop_i;
   assign step = (state_q == S_NEXT) && !last_entry && !stop_i;
   assign sent = (state_q == S_WR_BACK) && mem_ack;

   txr_trig_queue u_queue (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (scan_trig),
      .take_i (take),
      .drop_i (drop),
      .pend_o (pend)
   );

   txr_ring_idx #(.RING_LOG2(RING_LOG2)) u_idx (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (take),
      .step_i  (step),
      .sent_i  (sent),
      .entry_o (entry),
      .last_o  (last_entry)
   );

   txr_byte_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_flag_lane (
      .word_i (mem_rdata), .sel_i (2'd2), .byte_o (flag_byte));
   txr_byte_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_lenhi_lane (
      .word_i (mem_rdata), .sel_i (2'd0), .byte_o (len_hi));
   txr_byte_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_lenlo_lane (
      .word_i (mem_rdata), .sel_i (2'd1), .byte_o (len_lo));
   txr_byte_lane #(.BIG_ENDIAN(BIG_ENDIAN)) u_buf_lane (
      .word_i (word_q), .sel_i (baddr_q[1:0]), .byte_o (tx_data));

   // address arithmetic
   assign base      = init_ptr + dma_off;
   assign desc_addr = base + ADDR_W'(RING_OFS)
                      + (ADDR_W'(entry) * ADDR_W'(TXR_DESC_BYTES));
   assign buf_start = base + ADDR_W'(BUF_OFS)
                      + (ADDR_W'(entry) * ADDR_W'(BUF_BYTES));

   // stored length is negative; limit to one buffer
   assign neg_len  = ~{len_hi, len_lo} + 1'b1;
   assign cnt_load = (neg_len > LEN_CAP) ? CNT_W'(BUF_BYTES) : CNT_W'(neg_len);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cnt_q   <= '0;
         baddr_q <= '0;
         word_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= sent;
         case (state_q)
            S_IDLE: begin
               if (take) state_q <= S_RD_FLAG;
            end
            S_RD_FLAG: begin
               if (mem_ack)
                  state_q <= (flag_byte == TXR_FLAG_READY) ? S_RD_LEN : S_NEXT;
            end
            S_RD_LEN: begin
               if (mem_ack) begin
                  if (cnt_load == '0) begin
                     state_q <= S_WR_BACK;
                  end else begin
                     cnt_q   <= cnt_load;
                     baddr_q <= buf_start;
                     state_q <= S_RD_BUF;
                  end
               end
            end
            S_RD_BUF: begin
               if (mem_ack) begin
                  word_q  <= mem_rdata;
                  state_q <= S_SEND;
               end
            end
            S_SEND: begin
               if (tx_ready) begin
                  baddr_q <= baddr_q + 1'b1;
                  cnt_q   <= cnt_q - 1'b1;
                  if (cnt_q == CNT_W'(1))         state_q <= S_WR_BACK;
                  else if (baddr_q[1:0] == 2'b11) state_q <= S_RD_BUF;
               end
            end
            S_WR_BACK: begin
               if (mem_ack) state_q <= S_NEXT;
            end
            S_NEXT: begin
               state_q <= (last_entry || stop_i) ? S_IDLE : S_RD_FLAG;
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req  = 1'b0;
      mem_we   = 1'b0;
      mem_addr = desc_addr;
      case (state_q)
         S_RD_FLAG: mem_req = 1'b1;
         S_RD_LEN: begin
            mem_req  = 1'b1;
            mem_addr = desc_addr + ADDR_W'(4);
         end
         S_RD_BUF: begin
            mem_req  = 1'b1;
            mem_addr = {baddr_q[ADDR_W-1:2], 2'b00};
         end
         S_WR_BACK: begin
            mem_req = 1'b1;
            mem_we  = 1'b1;
         end
         default: ;
      endcase
   end

   assign mem_be    = mem_we ? FLAG_BE : 4'b0000;
   assign mem_wdata = {4{TXR_FLAG_DONE}};
   assign tx_valid  = (state_q == S_SEND);
   assign tx_last   = (state_q == S_SEND) && (cnt_q == CNT_W'(1));
   assign tx_done   = done_q;

   // R10: requests are held until acknowledged
   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

   // R10: stream bytes are held until accepted
   assert_stream_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

   // R6: each done pulse follows an acknowledged write-back
   assert_done_after_wr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> $past(mem_req && mem_we && mem_ack));

   // R6: done is a single-cycle pulse
   assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);

   // R2: a stopped idle engine issues no request next cycle
   assert_stop_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE && stop_i) |=> !mem_req);

   // R5: the stream pauses after the final byte of a frame
   assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_last) |=> !tx_valid);
endmodule

// File: tb/test_txr_ring_engine.sv
module test_txr_ring_engine;
   localparam int CLK_PERIOD = 10;
   localparam int MEM_BYTES  = 32768;
   localparam int RING_N     = 16;
   localparam int RING_OFS   = 152;
   localparam int BUF_OFS    = 280;
   localparam int BUF_BYTES  = 1544;
   localparam int BASE       = 32'h140;
   localparam int WD_CYCLES  = 150000;
   localparam int LOGN       = 8192;

   // slot table: {flag byte, stored length}
   localparam logic [23:0] TBL [RING_N] = '{
      {8'h83, 16'hFFF6}, {8'h80, 16'hFFF0}, {8'h83, 16'hFFFF}, {8'hC3, 16'hFFF0},
      {8'h83, 16'hFFEC}, {8'h03, 16'hFFF0}, {8'h82, 16'hFFF0}, {8'h83, 16'hFFFD},
      {8'h00, 16'hFFF0}, {8'h81, 16'hFFF0}, {8'h83, 16'hFFFC}, {8'h93, 16'hFFF0},
      {8'h83, 16'hFFF9}, {8'h87, 16'hFFF0}, {8'h83, 16'hFFFB}, {8'h83, 16'hFFF8}
   };

   logic        clk = 1'b0;
   logic        rst_n;
   logic        scan_trig;
   logic        stop_i;
   logic [31:0] init_ptr;
   logic [31:0] dma_off;
   logic        mem_req;
   logic        mem_we;
   logic [31:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;
   logic        mem_ack;
   logic [31:0] mem_rdata;
   logic        tx_valid;
   logic [7:0]  tx_data;
   logic        tx_last;
   logic        tx_ready;
   logic        tx_done;

   logic [7:0] mem   [MEM_BYTES];
   logic [7:0] exp_b [LOGN];
   logic       exp_l [LOGN];
   logic [7:0] got_b [LOGN];
   logic       got_l [LOGN];
   logic [7:0] sflag [RING_N];
   int en, exp_done, ptr_m;
   int gn = 0, dn = 0, req_cyc = 0;
   int total = 0, bad = 0;
   bit bp_en = 1'b0;
   int cyc = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   txr_ring_engine i_txr_ring_engine (
      .clk (clk), .rst_n (rst_n), .scan_trig (scan_trig), .stop_i (stop_i),
      .init_ptr (init_ptr), .dma_off (dma_off),
      .mem_req (mem_req), .mem_we (mem_we), .mem_addr (mem_addr), .mem_be (mem_be),
      .mem_wdata (mem_wdata), .mem_ack (mem_ack), .mem_rdata (mem_rdata),
      .tx_valid (tx_valid), .tx_data (tx_data), .tx_last (tx_last),
      .tx_ready (tx_ready), .tx_done (tx_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      tx_ready <= !bp_en || ((cyc % 3) != 1);
   end

   always @(negedge clk) begin
      if (tx_valid && tx_ready) begin
         got_b[gn % LOGN] = tx_data;
         got_l[gn % LOGN] = tx_last;
         gn++;
      end
      if (tx_done) dn++;
      if (mem_req) req_cyc++;
   end

   task automatic chk(input bit ok, input string what, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
      end
   endtask

   function automatic int desc_a(input int e);
      return BASE + RING_OFS + 8 * e;
   endfunction

   function automatic int buf_a(input int e);
      return BASE + BUF_OFS + BUF_BYTES * e;
   endfunction

   task automatic set_desc(input int e, input logic [7:0] fl, input logic [15:0] len);
      int d;
      d = desc_a(e);
      mem[d]   = 8'(e);
      mem[d+1] = 8'h10;
      mem[d+2] = fl;
      mem[d+3] = 8'h5A;
      mem[d+4] = len[15:8];
      mem[d+5] = len[7:0];
      mem[d+6] = 8'hEE;
      mem[d+7] = 8'hEE;
   endtask

   task automatic snap_flags();
      for (int e = 0; e < RING_N; e++) sflag[e] = mem[desc_a(e) + 2];
   endtask

   // reference pass built from the requirements
   task automatic model_scan();
      int p;
      p = ptr_m;
      for (int k = 0; k < RING_N - 1; k++) begin
         int e, n;
         logic [15:0] len, neg;
         e = (p + k) % RING_N;
         if (sflag[e] == 8'h83) begin
            len = {mem[desc_a(e) + 4], mem[desc_a(e) + 5]};
            neg = ~len + 16'd1;
            n = (int'(neg) > BUF_BYTES) ? BUF_BYTES : int'(neg);
            for (int j = 0; j < n; j++) begin
               exp_b[en] = mem[buf_a(e) + j];
               exp_l[en] = (j == n - 1);
               en++;
            end
            sflag[e] = 8'h03;
            exp_done++;
            ptr_m = (ptr_m + 1) % RING_N;
         end
      end
   endtask

   task automatic pulse_trig();
      @(negedge clk) scan_trig = 1'b1;
      @(negedge clk) scan_trig = 1'b0;
   endtask

   task automatic wait_quiet();
      int q;
      q = 0;
      while (q < 40) begin
         @(negedge clk);
         if (mem_req || tx_valid) q = 0;
         else q++;
      end
   endtask

   task automatic compare(input int g0, input int d0, input string tag);
      int bad_i, bad_l;
      bad_i = -1;
      bad_l = -1;
      chk(gn - g0 == en, {tag, " R4 R5 byte count"}, gn - g0, en);
      for (int i = 0; i < en && i < (gn - g0); i++) begin
         if (bad_i < 0 && got_b[(g0 + i) % LOGN] != exp_b[i]) bad_i = i;
         if (bad_l < 0 && got_l[(g0 + i) % LOGN] != exp_l[i]) bad_l = i;
      end
      chk(bad_i < 0, {tag, " R5 frame data, first bad index"}, bad_i, -1);
      chk(bad_l < 0, {tag, " R5 last flag, first bad index"}, bad_l, -1);
      chk(dn - d0 == exp_done, {tag, " R6 done pulses"}, dn - d0, exp_done);
      for (int e = 0; e < RING_N; e++)
         chk(mem[desc_a(e) + 2] == sflag[e], $sformatf("%s R3 R6 R7 R8 flag of slot %0d", tag, e),
             int'(mem[desc_a(e) + 2]), int'(sflag[e]));
   endtask

   task automatic mem_server();
      int lat;
      lat = 0;
      forever begin
         @(posedge clk);
         if (!rst_n || mem_ack) begin
            mem_ack <= 1'b0;
            lat = 0;
         end else if (mem_req) begin
            if (lat >= int'(mem_addr[3:2]) % 3) begin
               int a;
               a = int'(mem_addr[14:2]) * 4;
               if (mem_we) begin
                  if (mem_be[3]) mem[a]   = mem_wdata[31:24];
                  if (mem_be[2]) mem[a+1] = mem_wdata[23:16];
                  if (mem_be[1]) mem[a+2] = mem_wdata[15:8];
                  if (mem_be[0]) mem[a+3] = mem_wdata[7:0];
               end
               mem_rdata <= {mem[a], mem[a+1], mem[a+2], mem[a+3]};
               mem_ack   <= 1'b1;
               lat = 0;
            end else begin
               lat++;
            end
         end
      end
   endtask

   initial begin
      int g0, d0, r0, e0, e1;
      rst_n = 1'b0; scan_trig = 1'b0; stop_i = 1'b0;
      init_ptr = 32'h100; dma_off = 32'h40;
      mem_ack = 1'b0; mem_rdata = '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
      for (int e = 0; e < RING_N; e++)
         for (int j = 0; j < BUF_BYTES; j++)
            mem[buf_a(e) + j] = 8'((e * 7 + j * 3 + 1) & 255);
      fork
         mem_server();
         begin
            repeat (WD_CYCLES) @(posedge clk);
            chk(1'b0, "watchdog expired", cyc, WD_CYCLES);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
         end
      join_none

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: idle outputs after reset
      chk(mem_req == 1'b0, "R1 mem_req after reset", mem_req, 0);
      chk(tx_valid == 1'b0, "R1 tx_valid after reset", tx_valid, 0);
      chk(tx_done == 1'b0, "R1 tx_done after reset", tx_done, 0);

      // one loop walks the slot table
      for (int e = 0; e < RING_N; e++) set_desc(e, TBL[e][23:16], TBL[e][15:0]);

      // R2: stopped engine ignores a trigger, also after release
      stop_i = 1'b1;
      r0 = req_cyc; g0 = gn;
      pulse_trig();
      repeat (40) @(negedge clk);
      chk(req_cyc == r0, "R2 requests while stopped", req_cyc - r0, 0);
      stop_i = 1'b0;
      repeat (40) @(negedge clk);
      chk(req_cyc == r0, "R2 dropped trigger ran later", req_cyc - r0, 0);
      chk(gn == g0, "R2 bytes while stopped", gn - g0, 0);

      // R1 R7: first pass starts at slot 0, slot 15 is behind the start
      ptr_m = 0;
      snap_flags(); en = 0; exp_done = 0; g0 = gn; d0 = dn;
      model_scan();
      pulse_trig();
      wait_quiet();
      compare(g0, d0, "pass A");

      // R8: re-arm slot before the true index and before a position-based index
      mem[desc_a(6) + 2] = 8'h83;
      mem[desc_a(14) + 2] = 8'h83;
      bp_en = 1'b1;
      snap_flags(); en = 0; exp_done = 0; g0 = gn; d0 = dn;
      model_scan();
      pulse_trig();
      wait_quiet();
      compare(g0, d0, "pass B backpressure");
      bp_en = 1'b0;

      // R4: zero length completes without bytes, oversized length is capped
      set_desc(ptr_m, 8'h83, 16'h0000);
      set_desc((ptr_m + 1) % RING_N, 8'h83, 16'hF830);
      snap_flags(); en = 0; exp_done = 0; g0 = gn; d0 = dn;
      model_scan();
      pulse_trig();
      wait_quiet();
      compare(g0, d0, "pass C length edges");

      // R9: trigger during a running scan is queued
      e1 = ptr_m;
      e0 = (ptr_m + RING_N - 1) % RING_N;
      for (int e = 0; e < RING_N; e++)
         if (mem[desc_a(e) + 2] == 8'h83) mem[desc_a(e) + 2] = 8'h03;
      set_desc(e1, 8'h83, 16'hFFC4);
      set_desc(e0, 8'h03, 16'hFFF0);
      snap_flags(); en = 0; exp_done = 0; g0 = gn; d0 = dn;
      model_scan();
      sflag[e0] = 8'h83;
      model_scan();
      pulse_trig();
      begin
         int w;
         w = 0;
         while (gn == g0 && w < 2000) begin @(negedge clk); w++; end
      end
      mem[desc_a(e0) + 2] = 8'h83;
      pulse_trig();
      wait_quiet();
      compare(g0, d0, "pass D R9 queued");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule